// File: doc/BRIEF.md
# Multi-mode raster sync generator

This block generates the raster timing for a display from a single pixel clock. It keeps a horizontal pixel counter and a vertical line counter. From these it drives active-low horizontal and vertical sync pulses, and horizontal, vertical and combined blanking flags. It does not handle pixel data. Downstream pixel logic uses the counters as the current screen position and gates its colour output with the combined blank.

Two complete timing sets are built in: a 640x480 set and a 1024x768 set. A one-bit mode input chooses between them. Each set splits the line and the frame into four segments. Within a line or a frame they always come in this order: display, front porch, sync pulse, back porch. A count of zero is the first displayed pixel or line.

Both modes share one pair of counters and one set of comparators. The chosen mode is latched only on the last clock of a frame, so a frame never mixes two timing sets. Scanning is progressive: each frame is a whole number of lines.

Top module: `raster_sync_gen`

## Requirements
- R1: While `rst_ni` is low, `hcount_o` and `vcount_o` are 0, `hsync_o` and `vsync_o` are high (deasserted), and `hblank_o`, `vblank_o` and `blank_o` are low.
- R2: `hcount_o` steps by one on every clock. It returns to 0 after the value that is one less than the line length. The line length is the sum of the four horizontal segments of the active mode: 640+13+95+47 = 795 for mode 0, and 1024+24+136+160 = 1344 for mode 1.
- R3: `vcount_o` changes only on the clock where `hcount_o` wraps. At that clock it steps by one, or it returns to 0 when it is on the last line. The frame length is 480+13+2+33 = 528 lines for mode 0, and 768+9+6+23 = 806 lines for mode 1.
- R4: `hsync_o` is low exactly when `hcount_o` lies in the range [display+front porch, display+front porch+pulse). That is [653,748) for mode 0 and [1048,1184) for mode 1. It is high at all other counts.
- R5: `vsync_o` is low exactly when `vcount_o` lies in [493,495) for mode 0 and [777,783) for mode 1, that is [display+front porch, display+front porch+pulse). It is high at all other lines.
- R6: `hblank_o` is high exactly when `hcount_o` is at or beyond the horizontal display width: 640 for mode 0, 1024 for mode 1.
- R7: `vblank_o` is high exactly when `vcount_o` is at or beyond the vertical display height: 480 for mode 0, 768 for mode 1.
- R8: `blank_o` is high exactly when `hblank_o` or `vblank_o` is high, in the same cycle as the counters.
- R9: `mode_i` = 0 selects 640x480 and `mode_i` = 1 selects 1024x768. The active mode is 0 after reset. `mode_i` is sampled only on the clock where both counters are at their last values, and that value governs the whole next frame. Changes of `mode_i` at any other time have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Timing set request: 0 = 640x480, 1 = 1024x768 |
| hcount_o | output | H_W | Pixel position within the line |
| vcount_o | output | V_W | Line position within the frame |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| hblank_o | output | 1 | Horizontal position outside the display region |
| vblank_o | output | 1 | Vertical position outside the display region |
| blank_o | output | 1 | Either position outside the display region |

## Verification
The assertions assume the following about the parameters:
- The counter widths are large enough for each mode's totals.
- Every segment of both timing sets is nonzero.

The assertions place no limit on `mode_i`, which may toggle on any cycle. The stimulus follows these assumptions. It overrides both timing sets with short segments so that several whole frames fit in the run. It toggles `mode_i` in the middle of frames as well as just before frame ends. It also applies one asynchronous reset in the middle of a frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int SEG_W = 12;

  typedef struct packed {
    logic [SEG_W-1:0] disp;
    logic [SEG_W-1:0] fp;
    logic [SEG_W-1:0] pw;
    logic [SEG_W-1:0] bp;
  } seg_t;

  localparam seg_t VGA_H = '{disp: 12'd640,  fp: 12'd13, pw: 12'd95,  bp: 12'd47};
  localparam seg_t VGA_V = '{disp: 12'd480,  fp: 12'd13, pw: 12'd2,   bp: 12'd33};
  localparam seg_t XGA_H = '{disp: 12'd1024, fp: 12'd24, pw: 12'd136, bp: 12'd160};
  localparam seg_t XGA_V = '{disp: 12'd768,  fp: 12'd9,  pw: 12'd6,   bp: 12'd23};

  function automatic int unsigned seg_total(seg_t s);
    return int'(s.disp) + int'(s.fp) + int'(s.pw) + int'(s.bp);
  endfunction

  function automatic int unsigned sync_start(seg_t s);
    return int'(s.disp) + int'(s.fp);
  endfunction

  function automatic int unsigned sync_end(seg_t s);
    return int'(s.disp) + int'(s.fp) + int'(s.pw);
  endfunction

endpackage

// File: rtl/raster_mode_sel.sv
module raster_mode_sel
  import raster_pkg::*;
#(
  parameter seg_t M0_H = VGA_H,
  parameter seg_t M0_V = VGA_V,
  parameter seg_t M1_H = XGA_H,
  parameter seg_t M1_V = XGA_V
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic load_i,
  output logic mode_o,
  output seg_t h_seg_o,
  output seg_t v_seg_o
);

  localparam int NMODE = 2;
  seg_t h_tab [NMODE];
  seg_t v_tab [NMODE];
  logic mode_q;

  assign h_tab[0] = M0_H;
  assign h_tab[1] = M1_H;
  assign v_tab[0] = M0_V;
  assign v_tab[1] = M1_V;

  // mode latched on the last clock of a frame only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= 1'b0;
    else if (load_i) mode_q <= mode_i;
  end

  assign mode_o  = mode_q;
  assign h_seg_o = h_tab[mode_q];
  assign v_seg_o = v_tab[mode_q];

endmodule

// File: rtl/raster_axis_cnt.sv
module raster_axis_cnt
  import raster_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  seg_t         seg_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o,
  output logic         sync_no,
  output logic         blank_o,
  output logic         blank_nxt_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         sync_q, sync_d;
  logic         blank_q, blank_d;
  int unsigned  total_m1;
  int unsigned  cnt_d_u;

  assign total_m1 = seg_total(seg_i) - 1;
  assign last_o   = (32'(cnt_q) == total_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = last_o ? '0 : cnt_q + 1'b1;
  end

  // flags registered from the next count so they align with cnt_o
  assign cnt_d_u = 32'(cnt_d);
  assign blank_d = (cnt_d_u >= 32'(seg_i.disp));
  assign sync_d  = !((cnt_d_u >= sync_start(seg_i)) && (cnt_d_u < sync_end(seg_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sync_q  <= 1'b1;
      blank_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sync_q  <= sync_d;
      blank_q <= blank_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign sync_no     = sync_q;
  assign blank_o     = blank_q;
  assign blank_nxt_o = blank_d;

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_pkg::*;
#(
  parameter int   H_W  = 11,
  parameter int   V_W  = 10,
  parameter seg_t M0_H = VGA_H,
  parameter seg_t M0_V = VGA_V,
  parameter seg_t M1_H = XGA_H,
  parameter seg_t M1_V = XGA_V
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_i,
  output logic [H_W-1:0] hcount_o,
  output logic [V_W-1:0] vcount_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           hblank_o,
  output logic           vblank_o,
  output logic           blank_o
);

  seg_t h_seg, v_seg;
  logic act_mode;
  logic h_last, v_last, frame_last;
  logic h_blank_nxt, v_blank_nxt;
  logic blank_q;

  assign frame_last = h_last & v_last;

  raster_mode_sel #(
    .M0_H(M0_H), .M0_V(M0_V), .M1_H(M1_H), .M1_V(M1_V)
  ) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .load_i (frame_last),
    .mode_o (act_mode),
    .h_seg_o(h_seg),
    .v_seg_o(v_seg)
  );

  raster_axis_cnt #(.W(H_W)) u_hcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (1'b1),
    .seg_i      (h_seg),
    .cnt_o      (hcount_o),
    .last_o     (h_last),
    .sync_no    (hsync_o),
    .blank_o    (hblank_o),
    .blank_nxt_o(h_blank_nxt)
  );

  raster_axis_cnt #(.W(V_W)) u_vcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (h_last),
    .seg_i      (v_seg),
    .cnt_o      (vcount_o),
    .last_o     (v_last),
    .sync_no    (vsync_o),
    .blank_o    (vblank_o),
    .blank_nxt_o(v_blank_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blank_q <= 1'b0;
    else         blank_q <= h_blank_nxt | v_blank_nxt;
  end

  assign blank_o = blank_q;

endmodule

// File: rtl/raster_sync_chk.sv
module raster_sync_chk
  import raster_pkg::*;
#(
  parameter int   H_W  = 11,
  parameter int   V_W  = 10,
  parameter seg_t M0_H = VGA_H,
  parameter seg_t M0_V = VGA_V,
  parameter seg_t M1_H = XGA_H,
  parameter seg_t M1_V = XGA_V
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           act_mode,
  input logic [H_W-1:0] hcount_o,
  input logic [V_W-1:0] vcount_o,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           hblank_o,
  input logic           vblank_o,
  input logic           blank_o
);

  seg_t hs, vs;
  int unsigned hc, vc, hlast, vlast;

  assign hs    = act_mode ? M1_H : M0_H;
  assign vs    = act_mode ? M1_V : M0_V;
  assign hc    = 32'(hcount_o);
  assign vc    = 32'(vcount_o);
  assign hlast = seg_total(hs) - 1;
  assign vlast = seg_total(vs) - 1;

  AST_H_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc != hlast) |=> (32'(hcount_o) == 32'($past(hcount_o)) + 1)); // R2
  AST_H_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc == hlast) |=> (hcount_o == '0)); // R2
  AST_V_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc != hlast) |=> $stable(vcount_o)); // R3
  AST_V_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc == hlast && vc != vlast) |=> (32'(vcount_o) == 32'($past(vcount_o)) + 1)); // R3
  AST_V_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc == hlast && vc == vlast) |=> (vcount_o == '0)); // R3
  AST_HSYNC_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o == !(hc >= sync_start(hs) && hc < sync_end(hs))); // R4
  AST_VSYNC_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o == !(vc >= sync_start(vs) && vc < sync_end(vs))); // R5
  AST_HBLANK_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hblank_o == (hc >= 32'(hs.disp))); // R6
  AST_VBLANK_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o == (vc >= 32'(vs.disp))); // R7
  AST_BLANK_UNION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o == (hblank_o | vblank_o)); // R8
  AST_MODE_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_mode) |-> (hcount_o == '0 && vcount_o == '0)); // R9

endmodule

bind raster_sync_gen raster_sync_chk #(
  .H_W(H_W), .V_W(V_W), .M0_H(M0_H), .M0_V(M0_V), .M1_H(M1_H), .M1_V(M1_V)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .act_mode(act_mode),
  .hcount_o(hcount_o),
  .vcount_o(vcount_o),
  .hsync_o (hsync_o),
  .vsync_o (vsync_o),
  .hblank_o(hblank_o),
  .vblank_o(vblank_o),
  .blank_o (blank_o)
);

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb;
  import raster_pkg::*;

  // short segments so that whole frames fit in the run
  localparam seg_t T0_H = '{disp: 12'd8,  fp: 12'd2, pw: 12'd3, bp: 12'd2};
  localparam seg_t T0_V = '{disp: 12'd4,  fp: 12'd1, pw: 12'd2, bp: 12'd1};
  localparam seg_t T1_H = '{disp: 12'd12, fp: 12'd1, pw: 12'd4, bp: 12'd3};
  localparam seg_t T1_V = '{disp: 12'd6,  fp: 12'd2, pw: 12'd1, bp: 12'd2};

  // model tables: disp, fp, pw, bp
  int hseg [2][4] = '{'{8, 2, 3, 2}, '{12, 1, 4, 3}};
  int vseg [2][4] = '{'{4, 1, 2, 1}, '{6, 2, 1, 2}};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [10:0] hcount_o;
  logic [9:0]  vcount_o;
  logic        hsync_o, vsync_o, hblank_o, vblank_o, blank_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_hc = 0, m_vc = 0, m_mode = 0;

  always #2.5 clk_i = ~clk_i;

  raster_sync_gen #(
    .H_W(11), .V_W(10), .M0_H(T0_H), .M0_V(T0_V), .M1_H(T1_H), .M1_V(T1_V)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .hcount_o(hcount_o), .vcount_o(vcount_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .blank_o(blank_o)
  );

  function automatic int tot(int s[4]);
    return s[0] + s[1] + s[2] + s[3];
  endfunction

  // reference model: position and mode advance on each clock
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_hc <= 0; m_vc <= 0; m_mode <= 0;
    end else if (m_hc == tot(hseg[m_mode]) - 1) begin
      m_hc <= 0;
      if (m_vc == tot(vseg[m_mode]) - 1) begin
        m_vc   <= 0;
        m_mode <= int'(mode_i);
      end else begin
        m_vc <= m_vc + 1;
      end
    end else begin
      m_hc <= m_hc + 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int hd, hss, hse, vd, vss, vse;
    hd  = hseg[m_mode][0];
    hss = hd + hseg[m_mode][1];
    hse = hss + hseg[m_mode][2];
    vd  = vseg[m_mode][0];
    vss = vd + vseg[m_mode][1];
    vse = vss + vseg[m_mode][2];
    check(int'(hcount_o) == m_hc, "R2 R9 hcount", int'(hcount_o), m_hc);
    check(int'(vcount_o) == m_vc, "R3 R9 vcount", int'(vcount_o), m_vc);
    check(hsync_o == !(m_hc >= hss && m_hc < hse), "R4 hsync",
          int'(hsync_o), int'(!(m_hc >= hss && m_hc < hse)));
    check(vsync_o == !(m_vc >= vss && m_vc < vse), "R5 vsync",
          int'(vsync_o), int'(!(m_vc >= vss && m_vc < vse)));
    check(hblank_o == (m_hc >= hd), "R6 hblank", int'(hblank_o), int'(m_hc >= hd));
    check(vblank_o == (m_vc >= vd), "R7 vblank", int'(vblank_o), int'(m_vc >= vd));
    check(blank_o == (m_hc >= hd || m_vc >= vd), "R8 blank",
          int'(blank_o), int'(m_hc >= hd || m_vc >= vd));
  endtask

  always @(negedge clk_i) if (!done) compare_all();

  task automatic check_reset_state();
    check(hcount_o == '0 && vcount_o == '0, "R1 counters", int'(hcount_o) + int'(vcount_o), 0);
    check(hsync_o && vsync_o, "R1 syncs", int'(hsync_o) + int'(vsync_o), 2);
    check(!hblank_o && !vblank_o && !blank_o, "R1 blanks",
          int'(hblank_o) + int'(vblank_o) + int'(blank_o), 0);
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    mode_i = 1'b1;
    cycles(3);
    check_reset_state();
    rst_ni = 1'b1;
    // R9: first frame stays in mode 0 although mode 1 is requested
    cycles(60);
    check(m_mode == 0, "R9 first frame mode", m_mode, 0);
    cycles(120);
    check(m_mode == 1, "R9 mode 1 taken at frame start", m_mode, 1);
    // R9: mid-frame toggling has no effect on the current frame
    mode_i = 1'b0; cycles(37);
    mode_i = 1'b1; cycles(50);
    mode_i = 1'b0; cycles(3);
    mode_i = 1'b1;
    cycles(600);
    check(m_mode == 1, "R9 mode kept", m_mode, 1);
    mode_i = 1'b0;
    cycles(500);
    check(m_mode == 0, "R9 mode 0 restored", m_mode, 0);
    // R1: asynchronous reset in the middle of a frame
    cycles(17);
    #1 rst_ni = 1'b0;
    cycles(2);
    check_reset_state();
    mode_i = 1'b1;
    rst_ni = 1'b1;
    cycles(300);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule